// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Receiver

This block models the serial front end of a two-channel 12-bit converter that sits in a daisy chain with other serial devices. A host drives an active-low select, a serial clock and a data line. While the select is low, every rising serial clock edge moves one bit into a 16-bit shift register, most significant bit first. The bit that leaves the top of that register appears on the serial data output, so the next device in the chain sees the stream delayed by one word.

When the select returns high, the last 16 bits held in the register are decoded as one command. The bits are taken from the top down: a 3-bit prefix, then a 12-bit code field, then a trailing sub-bit that must be zero. A command can load channel A, load channel B, do nothing, or switch the data output to falling-edge timing. Software updates one converter in a chain by sending the no-op word to every other device in the chain during the same load.

The serial pins are sampled in the block's own clock domain. Each level must therefore be held for a few clock cycles.

Top module: `dual_dac_rx`

## Requirements
- R1: After reset, both code registers read 0, the serial data output is 0 and the output timing is rising-edge mode (`out_on_fall` = 0).
- R2: A bit is taken in only on a rising serial clock edge while the select is low. Clock pulses while the select is high leave the shift register and the serial data output unchanged.
- R3: On select release, a word with prefix (bits 15:13) = 010 and bit 0 = 0 loads bits 12:1 into channel A.
- R4: On select release, a word with prefix 110 and bit 0 = 0 loads bits 12:1 into channel B.
- R5: Prefix 000 with bit 12 = 0 is a no-op: codes and output mode do not change.
- R6: Prefix 000 with bits 12:9 = 1000 and bit 0 = 0 sets falling-edge output mode (`out_on_fall` = 1). The mode is left only through reset.
- R7: Words with any other prefix (001, 011, 100, 101, 111), prefix 000 with bits 12:9 equal to 1xxx but not 1000, or bit 0 = 1 have no effect.
- R8: In rising-edge mode, the serial data output changes only on a selected rising edge. After that edge it shows bit 15 of the shifted register, which is the bit that entered 16 edges earlier.
- R9: In falling-edge mode, the serial data output holds across the rising edge and changes only on the following falling edge while selected. It then shows bit 15 of the register.
- R10: Only the last 16 bits shifted before release are decoded. Earlier bits have already passed out of the register.
- R11: Code registers never change while the select is held low, even after a full command word has been shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dac_cs_n | input | 1 | Active-low select; its rising edge applies the command |
| dac_sclk | input | 1 | Serial clock, active high |
| dac_sdi | input | 1 | Serial data in, most significant bit first |
| dac_sdo | output | 1 | Serial data out to the next device in the chain |
| code_a | output | 12 | Channel A code register |
| code_b | output | 12 | Channel B code register |
| out_on_fall | output | 1 | 1 when the data output updates on falling serial clock edges |

## Verification
The assertions assume that the serial pins change slowly compared with the block clock. They also assume that the select never changes in the same cycle as a serial clock edge. Under those conditions each sampled rising edge, falling edge and select release is a single clean event. The stimulus holds every level of select, clock and data for four block clock cycles. Data is set up while the clock is low, and the select only moves while the clock is low. No edge is ever merged or split.

// File: rtl/dual_dac_rx_pkg.sv
package dual_dac_rx_pkg;

  // Command prefix occupies the top bits of the frame.
  localparam int unsigned PFX_W = 3;

  localparam logic [PFX_W-1:0] PFX_CTRL   = 3'b000;
  localparam logic [PFX_W-1:0] PFX_LOAD_A = 3'b010;
  localparam logic [PFX_W-1:0] PFX_LOAD_B = 3'b110;

  // Upper nibble of the code field selecting falling-edge output mode.
  localparam int unsigned KEY_W = 4;
  localparam logic [KEY_W-1:0] DFLT_KEY = 4'b1000;

  typedef enum logic [2:0] {
    CMD_IGNORE = 3'd0,
    CMD_NOP    = 3'd1,
    CMD_DFLT   = 3'd2,
    CMD_LOAD_A = 3'd3,
    CMD_LOAD_B = 3'd4
  } dac_cmd_e;

endpackage

// File: rtl/dual_dac_rx_edge.sv
module dual_dac_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sel_o,
  output logic rise_o,
  output logic fall_o,
  output logic cs_rel_o,
  output logic sdi_o
);

  logic s_cs_n_q, s_sclk_q, s_sdi_q;
  logic p_cs_n_q, p_sclk_q;
  logic s_cs_n_d, s_sclk_d, s_sdi_d;
  logic p_cs_n_d, p_sclk_d;

  always_comb begin
    s_cs_n_d = cs_n_i;
    s_sclk_d = sclk_i;
    s_sdi_d  = sdi_i;
    p_cs_n_d = s_cs_n_q;
    p_sclk_d = s_sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs_n_q <= 1'b1;
      s_sclk_q <= 1'b0;
      s_sdi_q  <= 1'b0;
      p_cs_n_q <= 1'b1;
      p_sclk_q <= 1'b0;
    end else begin
      s_cs_n_q <= s_cs_n_d;
      s_sclk_q <= s_sclk_d;
      s_sdi_q  <= s_sdi_d;
      p_cs_n_q <= p_cs_n_d;
      p_sclk_q <= p_sclk_d;
    end
  end

  assign sel_o    = ~s_cs_n_q;
  assign rise_o   =  s_sclk_q & ~p_sclk_q;
  assign fall_o   = ~s_sclk_q &  p_sclk_q;
  assign cs_rel_o =  s_cs_n_q & ~p_cs_n_q;
  assign sdi_o    =  s_sdi_q;

endmodule

// File: rtl/dual_dac_rx_shift.sv
module dual_dac_rx_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en_i,
  input  logic              fall_en_i,
  input  logic              fall_mode_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o
);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic              sdo_q, sdo_d;
  logic              sr_en, sdo_en;

  always_comb begin
    sr_en  = shift_en_i;
    sr_d   = {sr_q[WORD_W-2:0], sdi_i};
    sdo_en = 1'b0;
    sdo_d  = sdo_q;
    if (!fall_mode_i && shift_en_i) begin
      // Rising mode: output follows the bit about to become the MSB.
      sdo_en = 1'b1;
      sdo_d  = sr_q[WORD_W-2];
    end else if (fall_mode_i && fall_en_i) begin
      sdo_en = 1'b1;
      sdo_d  = sr_q[WORD_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
    end else if (sdo_en) begin
      sdo_q <= sdo_d;
    end
  end

  assign word_o = sr_q;
  assign sdo_o  = sdo_q;

endmodule

// File: rtl/dual_dac_rx_decode.sv
module dual_dac_rx_decode
  import dual_dac_rx_pkg::*;
#(
  parameter int unsigned CODE_W = 12,
  localparam int unsigned WORD_W = PFX_W + CODE_W + 1
) (
  input  logic [WORD_W-1:0] word_i,
  output dac_cmd_e          cmd_o,
  output logic [CODE_W-1:0] code_o
);

  logic [PFX_W-1:0]  pfx;
  logic [CODE_W-1:0] data;
  logic              sub;

  assign pfx  = word_i[WORD_W-1 -: PFX_W];
  assign data = word_i[CODE_W:1];
  assign sub  = word_i[0];

  always_comb begin
    cmd_o = CMD_IGNORE;
    if (!sub) begin
      case (pfx)
        PFX_CTRL: begin
          if (!data[CODE_W-1]) begin
            cmd_o = CMD_NOP;
          end else if (data[CODE_W-1 -: KEY_W] == DFLT_KEY) begin
            cmd_o = CMD_DFLT;
          end
        end
        PFX_LOAD_A: cmd_o = CMD_LOAD_A;
        PFX_LOAD_B: cmd_o = CMD_LOAD_B;
        default:    cmd_o = CMD_IGNORE;
      endcase
    end
  end

  assign code_o = data;

endmodule

// File: rtl/dual_dac_rx.sv
module dual_dac_rx
  import dual_dac_rx_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dac_cs_n,
  input  logic              dac_sclk,
  input  logic              dac_sdi,
  output logic              dac_sdo,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              out_on_fall
);

  localparam int unsigned WORD_W = PFX_W + CODE_W + 1;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  logic sel, rise_ev, fall_ev, cs_rel, sdi_s;

  dual_dac_rx_edge i_edge (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cs_n_i   (dac_cs_n),
    .sclk_i   (dac_sclk),
    .sdi_i    (dac_sdi),
    .sel_o    (sel),
    .rise_o   (rise_ev),
    .fall_o   (fall_ev),
    .cs_rel_o (cs_rel),
    .sdi_o    (sdi_s)
  );

  logic [WORD_W-1:0] shift_word;
  logic              fall_mode_q;

  dual_dac_rx_shift #(.WORD_W(WORD_W)) i_shift (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .shift_en_i  (rise_ev & sel),
    .fall_en_i   (fall_ev & sel),
    .fall_mode_i (fall_mode_q),
    .sdi_i       (sdi_s),
    .word_o      (shift_word),
    .sdo_o       (dac_sdo)
  );

  dac_cmd_e          cmd;
  logic [CODE_W-1:0] dec_code;

  dual_dac_rx_decode #(.CODE_W(CODE_W)) i_decode (
    .word_i (shift_word),
    .cmd_o  (cmd),
    .code_o (dec_code)
  );

  logic              upd_a, upd_b, upd_mode;
  logic [CODE_W-1:0] code_a_q, code_b_q;

  always_comb begin
    upd_a    = cs_rel && (cmd == CMD_LOAD_A);
    upd_b    = cs_rel && (cmd == CMD_LOAD_B);
    upd_mode = cs_rel && (cmd == CMD_DFLT);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      code_a_q    <= '0;
      code_b_q    <= '0;
      fall_mode_q <= 1'b0;
    end else begin
      if (upd_a)    code_a_q    <= dec_code;
      if (upd_b)    code_b_q    <= dec_code;
      if (upd_mode) fall_mode_q <= 1'b1;
    end
  end

  assign code_a      = code_a_q;
  assign code_b      = code_b_q;
  assign out_on_fall = fall_mode_q;

endmodule

// File: rtl/dual_dac_rx_chk.sv
module dual_dac_rx_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CODE_W = 12
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              sel,
  input logic              rise_ev,
  input logic              fall_ev,
  input logic              cs_rel,
  input logic              out_on_fall,
  input logic              dac_sdo,
  input logic [WORD_W-1:0] shift_word,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b
);

  // R11
  code_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cs_rel |=> $stable(code_a));

  // R11
  code_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cs_rel |=> $stable(code_b));

  // R6
  fall_mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_on_fall |=> out_on_fall);

  // R6
  fall_mode_on_release_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(out_on_fall) |-> $past(cs_rel));

  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(rise_ev && sel) |=> $stable(shift_word));

  // R8
  sdo_rise_mode_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!out_on_fall && !(rise_ev && sel)) |=> $stable(dac_sdo));

  // R9
  sdo_fall_mode_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_on_fall && !(fall_ev && sel)) |=> $stable(dac_sdo));

endmodule

bind dual_dac_rx dual_dac_rx_chk #(.WORD_W(WORD_W), .CODE_W(CODE_W)) i_chk (
  .clk         (clk),
  .rst_s_n     (rst_s_n),
  .sel         (sel),
  .rise_ev     (rise_ev),
  .fall_ev     (fall_ev),
  .cs_rel      (cs_rel),
  .out_on_fall (out_on_fall),
  .dac_sdo     (dac_sdo),
  .shift_word  (shift_word),
  .code_a      (code_a),
  .code_b      (code_b)
);

// File: tb/test_dual_dac_rx.sv
`timescale 1ns/1ps
module test_dual_dac_rx;

  localparam int H     = 4;
  localparam int LIMIT = 200000;
  localparam int NVEC  = 8;

  // {word, expected code_a, expected code_b} after each frame, applied in order
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h5578, 12'hABC, 12'h000},  // R3 load A 0xABC
    {16'hC246, 12'hABC, 12'h123},  // R4 load B 0x123
    {16'h0FFE, 12'hABC, 12'h123},  // R5 no-op
    {16'hBFFE, 12'hABC, 12'h123},  // R7 prefix 101 ignored
    {16'h4001, 12'hABC, 12'h123},  // R7 sub-bit set ignored
    {16'h1386, 12'hABC, 12'h123},  // R7 prefix 000 key 1001 ignored
    {16'h5FFE, 12'hFFF, 12'h123},  // R3 full-scale A
    {16'hC000, 12'hFFF, 12'h000}   // R4 zero B
  };

  logic        clk = 1'b0;
  logic        rst_n, dac_cs_n, dac_sclk, dac_sdi;
  logic        dac_sdo, out_on_fall;
  logic [11:0] code_a, code_b;

  int          checks = 0;
  int          errors = 0;
  int          cyc    = 0;
  logic [15:0] shadow;
  bit          fall_exp;

  always #2.5 clk = ~clk;

  dual_dac_rx i_dual_dac_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .dac_cs_n    (dac_cs_n),
    .dac_sclk    (dac_sclk),
    .dac_sdi     (dac_sdi),
    .dac_sdo     (dac_sdo),
    .code_a      (code_a),
    .code_b      (code_b),
    .out_on_fall (out_on_fall)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n, input bit chk_sdo);
    for (int i = n - 1; i >= 0; i--) begin
      logic [15:0] prev;
      dac_sdi = bits[i];
      idle(H);
      prev     = shadow;
      dac_sclk = 1'b1;
      shadow   = {shadow[14:0], bits[i]};
      idle(H);
      if (chk_sdo) begin
        if (fall_exp) chk("R9 sdo after rise", 32'(dac_sdo), 32'(prev[15]));
        else          chk("R8 sdo after rise", 32'(dac_sdo), 32'(shadow[15]));
      end
      dac_sclk = 1'b0;
      idle(H);
      if (chk_sdo) chk("R8 R9 sdo after fall", 32'(dac_sdo), 32'(shadow[15]));
    end
  endtask

  task automatic frame(input logic [31:0] bits, input int n, input bit chk_sdo);
    dac_cs_n = 1'b0;
    idle(H);
    shift_bits(bits, n, chk_sdo);
    dac_cs_n = 1'b1;
    idle(H);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    dac_cs_n = 1'b1;
    dac_sclk = 1'b0;
    dac_sdi  = 1'b0;
    shadow   = '0;
    fall_exp = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 code_a", 32'(code_a), 32'h0);
    chk("R1 code_b", 32'(code_b), 32'h0);
    chk("R1 sdo", 32'(dac_sdo), 32'h0);
    chk("R1 out_on_fall", 32'(out_on_fall), 32'h0);

    // Vector table: R3 R4 R5 R7
    for (int v = 0; v < NVEC; v++) begin
      frame({16'h0, VEC[v][39:24]}, 16, 1'b0);
      chk("R3 R4 R5 R7 table code_a", 32'(code_a), 32'(VEC[v][23:12]));
      chk("R3 R4 R5 R7 table code_b", 32'(code_b), 32'(VEC[v][11:0]));
      chk("R5 R7 table mode", 32'(out_on_fall), 32'h0);
    end

    // R11: full word shifted, select still low
    dac_cs_n = 1'b0;
    idle(H);
    shift_bits(32'h0000_4642, 16, 1'b0);
    chk("R11 code_a before release", 32'(code_a), 32'hFFF);
    dac_cs_n = 1'b1;
    idle(H);
    chk("R3 code_a after release", 32'(code_a), 32'h321);

    // R2: clock pulses with select high do nothing
    for (int p = 0; p < 16; p++) begin
      dac_sdi  = 1'b1;
      idle(H);
      dac_sclk = 1'b1;
      idle(H);
      dac_sclk = 1'b0;
      idle(H);
    end
    chk("R2 sdo unchanged", 32'(dac_sdo), 32'(shadow[15]));
    chk("R2 code_a unchanged", 32'(code_a), 32'h321);
    chk("R2 code_b unchanged", 32'(code_b), 32'h000);

    // R8 R2: next frame pushes previous word out on sdo
    frame(32'h0000_CB4A, 16, 1'b1);
    chk("R4 code_b", 32'(code_b), 32'h5A5);

    // R10: 32 bits, only last 16 decoded
    frame(32'hD554_41E0, 32, 1'b0);
    chk("R10 code_a", 32'(code_a), 32'h0F0);
    chk("R10 code_b", 32'(code_b), 32'h5A5);

    // R6: force falling-edge mode
    frame(32'h0000_10B4, 16, 1'b0);
    fall_exp = 1'b1;
    chk("R6 out_on_fall", 32'(out_on_fall), 32'h1);
    chk("R6 code_a unchanged", 32'(code_a), 32'h0F0);
    chk("R6 code_b unchanged", 32'(code_b), 32'h5A5);

    // R9: falling-edge output timing
    frame(32'h0000_5FFE, 16, 1'b1);
    chk("R3 code_a in fall mode", 32'(code_a), 32'hFFF);
    chk("R6 mode sticky", 32'(out_on_fall), 32'h1);

    // R1: reset mid-run
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(4);
    shadow   = '0;
    fall_exp = 1'b0;
    chk("R1 code_a after reset", 32'(code_a), 32'h0);
    chk("R1 code_b after reset", 32'(code_b), 32'h0);
    chk("R1 mode after reset", 32'(out_on_fall), 32'h0);
    chk("R1 sdo after reset", 32'(dac_sdo), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule